// File: doc/BRIEF.md
# NAND Flash Bus Timing Sequencer

This block sits between a simple host request port and the pins of an external NAND flash device. A host asks for one read or write of 8, 16 or 32 bits. The block turns that request into one or more timed bus cycles on a memory bus that is 8 or 16 bits wide. It steps through a programmable setup, strobe and hold phase for each cycle and drives chip enable, the write strobe, the read strobe and a data bus with a separate output enable. When every part of the request has finished, it returns one completion pulse, and on a read it also returns the assembled data word.

The same access time applies to each bus cycle. The setup phase has a fixed extra of two clocks and the strobe phase has a fixed extra of one clock. The hold phase has no extra. On writes, a separate count keeps the data drivers off at the start of each cycle. As an option, the block can watch an active-low busy input from the device at the end of hold and keep chip enable low until the device is ready. All timing values are captured when a request is accepted.

The host issues a request as a single-cycle `reqValid` pulse while the block is idle, then waits for `rspReady` or `rspError` before it sends the next one. Size encoding on `reqSize` is 0 for a byte, 1 for a halfword and 2 for a word. Code 3 is rejected.

Top module: `nand_bus_seq`

## Requirements
- R1: After a request is accepted, chip enable (`memCeN`) goes low in the next cycle. Each bus cycle starts with a setup phase of `cfgSetup`+2 clocks in which both strobes stay high.
- R2: The setup phase is followed by a strobe phase of `cfgWait`+1 clocks. During it, `memWeN` is low on writes and `memReN` is low on reads, and the two strobes are never low together.
- R3: A hold phase of exactly `cfgHold` clocks follows, with both strobes high. A value of 0 skips the hold phase. Without busy stalls, one bus cycle lasts `cfgSetup`+`cfgWait`+`cfgHold`+3 clocks, and chip enable stays low across every cycle of one request.
- R4: On a write, `memDataOe` stays low for the first `cfgHiz` clocks of every bus cycle. It is then high until the cycle ends, and `memDataOut` carries that cycle's part of the write data.
- R5: On a read, `memDataOe` is never high. `memDataIn` is captured on the last clock of the strobe phase. With an 8-bit memory, only bits 7:0 of `memDataIn` are used.
- R6: With `cfgMemWide`=0 (8-bit memory), a byte request takes 1 bus cycle, a halfword request 2 and a word request 4. The byte parts go out in ascending order, starting with bits 7:0.
- R7: With `cfgMemWide`=1 (16-bit memory), a halfword request takes 1 bus cycle and a word request 2, starting with bits 15:0. A byte read takes 1 cycle and returns bits 7:0 with the upper bits zeroed.
- R8: A byte write to a 16-bit memory, or any request with size code 3, raises `rspError` for one cycle, one cycle after the request. It starts no bus cycle and does not assert `rspReady`.
- R9: With `cfgWaitEn`=1, if the synchronized `memWaitN` is low at the end of a cycle's hold phase, chip enable stays low with both strobes high. In that case `rspReady` appears 3 clocks after `memWaitN` rises, because of the two-flop synchronizer plus the state update.
- R10: With `cfgWaitEn`=0, `memWaitN` has no effect on timing.
- R11: All timing values, the bus width and the wait enable are captured when a request is accepted. Changing them during an access does not alter that access.
- R12: During and right after reset, `memCeN`, `memWeN` and `memReN` are high, and `memDataOe`, `rspReady` and `rspError` are low.
- R13: `rspReady` is a single-cycle pulse. It appears in the cycle where `memCeN` returns high after the last bus cycle, and `rspRdata` holds the assembled, size-masked read word at that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Single-cycle request pulse, taken while idle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqSize | input | 2 | 0 byte, 1 halfword, 2 word, 3 invalid |
| reqWdata | input | 32 | Write data |
| cfgMemWide | input | 1 | 0 = 8-bit memory, 1 = 16-bit memory |
| cfgSetup | input | 8 | Setup count (phase lasts value+2) |
| cfgWait | input | 8 | Strobe count (phase lasts value+1) |
| cfgHold | input | 8 | Hold count (phase lasts value) |
| cfgHiz | input | 8 | Clocks of data high-Z at the start of each write cycle |
| cfgWaitEn | input | 1 | Enable busy monitoring at the end of hold |
| memWaitN | input | 1 | Active-low busy from the device, asynchronous |
| memDataIn | input | 16 | Data bus input from the device |
| memCeN | output | 1 | Chip enable, active low |
| memWeN | output | 1 | Write strobe, active low |
| memReN | output | 1 | Read strobe, active low |
| memDataOut | output | 16 | Data bus output value |
| memDataOe | output | 1 | Data bus output enable |
| rspReady | output | 1 | Completion pulse |
| rspError | output | 1 | Rejected-request pulse |
| rspRdata | output | 32 | Assembled read data |

## Verification
For a request accepted at clock edge E0, the completion pulse is due at edge E0 + parts×(setup+wait+hold+3) + 1, and a rejection is due at edge E0+1. The scoreboard stores that figure together with the expected chip-enable-low count, the number and width of strobe pulses, and the count of cycles with the drivers on. It compares the measured cycle distance at the first sample that shows the pulse. In a stalled access, the completion pulse is due 3 edges after `memWaitN` rises, and the bench checks that distance against the release time it records. All outputs are sampled shortly after the falling clock edge, so every register along the path has settled before it is read.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_WAIT,
    ST_HOLD,
    ST_BUSY
  } seqState_t;

  // strobes from the sequencer FSM to the datapath
  typedef struct packed {
    logic       loadReq;    // capture request fields
    logic       partStart;  // next cycle is the first setup clock of a part
    logic       inPart;     // an access is in progress
    logic       capture;    // last strobe clock of a read part
    logic [1:0] partIdx;    // current part, least significant first
  } dpCtl_t;

  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_HALF = 2'd1;
  localparam logic [1:0] SZ_WORD = 2'd2;
  localparam logic [1:0] SZ_BAD  = 2'd3;

endpackage

// File: rtl/nand_seq_sync.sv
module nand_seq_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);

  logic [STAGES-1:0] shift;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift <= '1;
        else        shift <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) shift <= '1;
        else        shift <= {shift[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = shift[STAGES-1];

endmodule

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reqValid,
  input  logic             reqWrite,
  input  logic [1:0]       reqSize,
  input  logic             cfgMemWide,
  input  logic [CNT_W-1:0] cfgSetup,
  input  logic [CNT_W-1:0] cfgWait,
  input  logic [CNT_W-1:0] cfgHold,
  input  logic             cfgWaitEn,
  input  logic             waitSync,
  output logic             ceN,
  output logic             weN,
  output logic             reN,
  output logic             rspReady,
  output logic             rspError,
  output dpCtl_t           dpCtl
);

  localparam int CW = CNT_W + 1;

  seqState_t        state;
  logic [CW-1:0]    cnt;
  logic [CNT_W-1:0] setupL, waitL, holdL;
  logic             waitEnL, writeL;
  logic [1:0]       partIdx, lastPart, reqLast;
  logic             accept, reject, start;
  logic             phaseEnd, leaveActive, stallWait, partEnd, isLast;

  // index of the last part for the incoming request
  always_comb begin
    if (cfgMemWide) begin
      reqLast = (reqSize == SZ_WORD) ? 2'd1 : 2'd0;
    end else begin
      case (reqSize)
        SZ_BYTE: reqLast = 2'd0;
        SZ_HALF: reqLast = 2'd1;
        default: reqLast = 2'd3;
      endcase
    end
  end

  assign accept      = (state == ST_IDLE) && reqValid;
  assign reject      = accept && ((reqSize == SZ_BAD) ||
                                  (cfgMemWide && reqWrite && reqSize == SZ_BYTE));
  assign start       = accept && !reject;
  assign phaseEnd    = (cnt == '0);
  assign leaveActive = phaseEnd && (((state == ST_WAIT) && (holdL == '0)) ||
                                    (state == ST_HOLD));
  assign stallWait   = leaveActive && waitEnL && !waitSync;
  assign partEnd     = (leaveActive && !stallWait) ||
                       ((state == ST_BUSY) && waitSync);
  assign isLast      = (partIdx == lastPart);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      cnt      <= '0;
      setupL   <= '0;
      waitL    <= '0;
      holdL    <= '0;
      waitEnL  <= 1'b0;
      writeL   <= 1'b0;
      partIdx  <= '0;
      lastPart <= '0;
      rspReady <= 1'b0;
      rspError <= 1'b0;
    end else begin
      rspReady <= partEnd && isLast;
      rspError <= reject;
      case (state)
        ST_IDLE: begin
          if (start) begin
            setupL   <= cfgSetup;
            waitL    <= cfgWait;
            holdL    <= cfgHold;
            waitEnL  <= cfgWaitEn;
            writeL   <= reqWrite;
            lastPart <= reqLast;
            partIdx  <= '0;
            cnt      <= {1'b0, cfgSetup} + CW'(1);
            state    <= ST_SETUP;
          end
        end
        ST_SETUP: begin
          if (phaseEnd) begin
            state <= ST_WAIT;
            cnt   <= {1'b0, waitL};
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_WAIT: begin
          if (phaseEnd) begin
            if (holdL != '0) begin
              state <= ST_HOLD;
              cnt   <= {1'b0, holdL} - CW'(1);
            end
          end else begin
            cnt <= cnt - CW'(1);
          end
        end
        ST_HOLD: begin
          if (!phaseEnd) cnt <= cnt - CW'(1);
        end
        ST_BUSY: ;
        default: state <= ST_IDLE;
      endcase

      if (stallWait) state <= ST_BUSY;

      if (partEnd) begin
        if (isLast) begin
          state <= ST_IDLE;
        end else begin
          partIdx <= partIdx + 2'd1;
          state   <= ST_SETUP;
          cnt     <= {1'b0, setupL} + CW'(1);
        end
      end
    end
  end

  assign ceN = (state == ST_IDLE);
  assign weN = !((state == ST_WAIT) && writeL);
  assign reN = !((state == ST_WAIT) && !writeL);

  assign dpCtl.loadReq   = start;
  assign dpCtl.partStart = start || (partEnd && !isLast);
  assign dpCtl.inPart    = (state != ST_IDLE);
  assign dpCtl.capture   = (state == ST_WAIT) && phaseEnd && !writeL;
  assign dpCtl.partIdx   = partIdx;

endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int MEM_W  = 16,
  parameter int HOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  dpCtl_t            ctl,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  input  logic              cfgMemWide,
  input  logic [CNT_W-1:0]  cfgHiz,
  input  logic [MEM_W-1:0]  memDataIn,
  output logic [MEM_W-1:0]  memDataOut,
  output logic              memDataOe,
  output logic [HOST_W-1:0] rspRdata
);

  localparam int NB = HOST_W / 8;

  logic [NB-1:0][7:0] wdB, rdB;
  logic [1:0]         sizeL;
  logic               wideL, writeL;
  logic [CNT_W-1:0]   hizL, hizCnt;
  logic [1:0]         loIdx, hiIdx;

  assign loIdx = {ctl.partIdx[0], 1'b0};
  assign hiIdx = {ctl.partIdx[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wdB    <= '0;
      rdB    <= '0;
      sizeL  <= SZ_BYTE;
      wideL  <= 1'b0;
      writeL <= 1'b0;
      hizL   <= '0;
      hizCnt <= '0;
    end else begin
      if (ctl.loadReq) begin
        wdB    <= reqWdata;
        sizeL  <= reqSize;
        wideL  <= cfgMemWide;
        writeL <= reqWrite;
        hizL   <= cfgHiz;
        rdB    <= '0;
      end
      if (ctl.partStart) begin
        hizCnt <= ctl.loadReq ? cfgHiz : hizL;
      end else if (hizCnt != '0) begin
        hizCnt <= hizCnt - CNT_W'(1);
      end
      if (ctl.capture) begin
        if (wideL) begin
          rdB[loIdx] <= memDataIn[7:0];
          rdB[hiIdx] <= memDataIn[15:8];
        end else begin
          rdB[ctl.partIdx] <= memDataIn[7:0];
        end
      end
    end
  end

  assign memDataOut = wideL ? {wdB[hiIdx], wdB[loIdx]}
                            : {{(MEM_W-8){1'b0}}, wdB[ctl.partIdx]};
  assign memDataOe  = ctl.inPart && writeL && (hizCnt == '0);

  always_comb begin
    case (sizeL)
      SZ_BYTE: rspRdata = {{(HOST_W-8){1'b0}}, rdB[0]};
      SZ_HALF: rspRdata = {{(HOST_W-16){1'b0}}, rdB[1], rdB[0]};
      default: rspRdata = rdB;
    endcase
  end

endmodule

// File: rtl/nand_bus_seq.sv
module nand_bus_seq
  import nand_seq_pkg::*;
#(
  parameter int CNT_W       = 8,
  parameter int MEM_W       = 16,
  parameter int HOST_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqSize,
  input  logic [HOST_W-1:0] reqWdata,
  input  logic              cfgMemWide,
  input  logic [CNT_W-1:0]  cfgSetup,
  input  logic [CNT_W-1:0]  cfgWait,
  input  logic [CNT_W-1:0]  cfgHold,
  input  logic [CNT_W-1:0]  cfgHiz,
  input  logic              cfgWaitEn,
  input  logic              memWaitN,
  input  logic [MEM_W-1:0]  memDataIn,
  output logic              memCeN,
  output logic              memWeN,
  output logic              memReN,
  output logic [MEM_W-1:0]  memDataOut,
  output logic              memDataOe,
  output logic              rspReady,
  output logic              rspError,
  output logic [HOST_W-1:0] rspRdata
);

  logic   waitSync;
  dpCtl_t dpCtl;

  nand_seq_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (memWaitN),
    .dout (waitSync)
  );

  nand_seq_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .cfgMemWide(cfgMemWide),
    .cfgSetup  (cfgSetup),
    .cfgWait   (cfgWait),
    .cfgHold   (cfgHold),
    .cfgWaitEn (cfgWaitEn),
    .waitSync  (waitSync),
    .ceN       (memCeN),
    .weN       (memWeN),
    .reN       (memReN),
    .rspReady  (rspReady),
    .rspError  (rspError),
    .dpCtl     (dpCtl)
  );

  nand_seq_dp #(.CNT_W(CNT_W), .MEM_W(MEM_W), .HOST_W(HOST_W)) u_dp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctl       (dpCtl),
    .reqWrite  (reqWrite),
    .reqSize   (reqSize),
    .reqWdata  (reqWdata),
    .cfgMemWide(cfgMemWide),
    .cfgHiz    (cfgHiz),
    .memDataIn (memDataIn),
    .memDataOut(memDataOut),
    .memDataOe (memDataOe),
    .rspRdata  (rspRdata)
  );

endmodule

// File: rtl/nand_seq_chk.sv
module nand_seq_chk (
  input logic clk,
  input logic rst_n,
  input logic memCeN,
  input logic memWeN,
  input logic memReN,
  input logic memDataOe,
  input logic rspReady,
  input logic rspError
);

  // R2: the two strobes are never active together
  a_r2_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!memWeN && !memReN));

  // R2: a strobe is only active inside a chip-enabled access
  a_r2_strobe_in_ce: assert property (@(posedge clk) disable iff (!rst_n)
    (!memWeN || !memReN) |-> !memCeN);

  // R5: drivers stay off while the read strobe is active
  a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    !memReN |-> !memDataOe);

  // R13: completion is a one-cycle pulse
  a_r13_ready_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rspReady |=> !rspReady);

  // R13: chip enable returns high exactly with the completion pulse
  a_r13_ready_with_ce: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(memCeN) |-> rspReady);

  // R8: a rejection never coincides with an access on the bus
  a_r8_err_no_ce: assert property (@(posedge clk) disable iff (!rst_n)
    rspError |-> (memCeN && !rspReady));

endmodule

bind nand_bus_seq nand_seq_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .memCeN   (memCeN),
  .memWeN   (memWeN),
  .memReN   (memReN),
  .memDataOe(memDataOe),
  .rspReady (rspReady),
  .rspError (rspError)
);

// File: tb/nand_bus_seq_test.sv
`timescale 1ns/1ps
module nand_bus_seq_test;

  typedef struct {
    bit          isErr;
    bit          isWrite;
    int          expLat;
    int          expCe;
    int          expPulses;
    int          expWidth;
    int          expOe;
    logic [31:0] expRdata;
    string       tag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [1:0]  reqSize = 2'd0;
  logic [31:0] reqWdata = '0;
  logic        cfgMemWide = 1'b0;
  logic [7:0]  cfgSetup = '0, cfgWait = '0, cfgHold = '0, cfgHiz = '0;
  logic        cfgWaitEn = 1'b0;
  logic        memWaitN = 1'b1;
  logic [15:0] memDataIn;
  logic        memCeN, memWeN, memReN, memDataOe, rspReady, rspError;
  logic [15:0] memDataOut;
  logic [31:0] rspRdata;

  int nChecks = 0, nFails = 0;
  int cycleCnt = 0, reqCycle = 0, doneCycle = 0;
  item_t sbQ[$];

  // memory model and monitor state
  logic [31:0] curWdata = '0, curMemWord = '0;
  bit          curWide = 1'b0;
  int          readIdx = 0;
  int          ceCnt = 0, oeCnt = 0, pulses = 0, runLen = 0;
  int          widthErr = 0, dataErr = 0;
  bit          prevLow = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cycleCnt <= cycleCnt + 1;

  assign memDataIn = curWide ? 16'(curMemWord >> (16 * readIdx))
                             : {8'hA5, 8'(curMemWord >> (8 * readIdx))};

  nand_bus_seq uut (
    .clk(clk), .rst_n(rst_n), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqSize(reqSize), .reqWdata(reqWdata), .cfgMemWide(cfgMemWide),
    .cfgSetup(cfgSetup), .cfgWait(cfgWait), .cfgHold(cfgHold), .cfgHiz(cfgHiz),
    .cfgWaitEn(cfgWaitEn), .memWaitN(memWaitN), .memDataIn(memDataIn),
    .memCeN(memCeN), .memWeN(memWeN), .memReN(memReN), .memDataOut(memDataOut),
    .memDataOe(memDataOe), .rspReady(rspReady), .rspError(rspError),
    .rspRdata(rspRdata)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] partValue(input logic [31:0] w, input bit wide, input int i);
    return wide ? 16'(w >> (16 * i)) : {8'h00, 8'(w >> (8 * i))};
  endfunction

  // monitor: samples 1 ns after the falling edge
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (!memCeN) ceCnt++;
      if (!memCeN && memDataOe) oeCnt++;
      if (!memWeN || !memReN) begin
        runLen++;
        if (!memWeN && (!memDataOe || memDataOut != partValue(curWdata, curWide, pulses)))
          dataErr++;
      end else if (prevLow) begin
        if (sbQ.size() != 0 && runLen != sbQ[0].expWidth) widthErr++;
        pulses++;
        runLen = 0;
        readIdx++;
      end
      prevLow = !memWeN || !memReN;
      if (rspReady || rspError) begin
        if (sbQ.size() == 0) begin
          check(1'b0, "R13", "unexpected response", 32'(rspReady), 32'd0);
        end else begin
          item_t it;
          it = sbQ.pop_front();
          doneCycle = cycleCnt;
          check(rspError == it.isErr && rspReady == !it.isErr, it.tag, "response kind",
                32'(rspError), 32'(it.isErr));
          if (it.expLat >= 0)
            check(cycleCnt - reqCycle == it.expLat, it.tag, "latency",
                  32'(cycleCnt - reqCycle), 32'(it.expLat));
          if (it.expCe >= 0)
            check(ceCnt == it.expCe, it.tag, "chip enable low clocks", 32'(ceCnt), 32'(it.expCe));
          check(pulses == it.expPulses, it.tag, "strobe pulses", 32'(pulses), 32'(it.expPulses));
          check(widthErr == 0, it.tag, "strobe width errors", 32'(widthErr), 32'd0);
          if (it.expCe >= 0)
            check(oeCnt == it.expOe, it.tag, "driven clocks", 32'(oeCnt), 32'(it.expOe));
          if (it.isWrite)
            check(dataErr == 0, it.tag, "write data errors", 32'(dataErr), 32'd0);
          else if (!it.isErr)
            check(rspRdata == it.expRdata, it.tag, "read data", rspRdata, it.expRdata);
        end
        ceCnt = 0; oeCnt = 0; pulses = 0; runLen = 0;
        widthErr = 0; dataErr = 0; readIdx = 0;
      end
    end
  end

  task automatic startAccess(input bit wr, input logic [1:0] sz, input logic [31:0] wd,
                             input logic [31:0] mw, input bit wide, input int s, input int w,
                             input int h, input int hz, input bit wen, input bit skipTime,
                             input string tag);
    item_t it;
    int parts, a;
    @(negedge clk);
    cfgMemWide = wide; cfgSetup = 8'(s); cfgWait = 8'(w); cfgHold = 8'(h);
    cfgHiz = 8'(hz); cfgWaitEn = wen;
    curWdata = wd; curWide = wide; curMemWord = mw;
    parts = wide ? ((sz == 2'd2) ? 2 : 1) : ((sz == 2'd0) ? 1 : (sz == 2'd1) ? 2 : 4);
    a = parts * (s + w + h + 3);
    it.isErr = (sz == 2'd3) || (wide && wr && sz == 2'd0);
    it.isWrite = wr && !it.isErr;
    it.tag = tag;
    it.expWidth = w + 1;
    it.expRdata = (sz == 2'd0) ? (mw & 32'hFF) : (sz == 2'd1) ? (mw & 32'hFFFF) : mw;
    if (it.isErr) begin
      it.expLat = 1; it.expCe = 0; it.expPulses = 0; it.expOe = 0;
    end else begin
      it.expLat = skipTime ? -1 : a + 1;
      it.expCe = skipTime ? -1 : a;
      it.expPulses = parts;
      it.expOe = wr ? a - parts * hz : 0;
    end
    sbQ.push_back(it);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqWdata = wd;
    reqCycle = cycleCnt;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic waitDone();
    while (sbQ.size() != 0) @(negedge clk);
    check(!rspReady && !rspError && memCeN, "R13", "idle after completion",
          {29'd0, rspReady, rspError, memCeN}, 32'd1);
  endtask

  task automatic access(input bit wr, input logic [1:0] sz, input logic [31:0] wd,
                        input logic [31:0] mw, input bit wide, input int s, input int w,
                        input int h, input int hz, input bit wen, input string tag);
    startAccess(wr, sz, wd, mw, wide, s, w, h, hz, wen, 1'b0, tag);
    waitDone();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(memCeN && memWeN && memReN && !memDataOe && !rspReady && !rspError, "R12",
          "outputs in reset", {26'd0, memCeN, memWeN, memReN, memDataOe, rspReady, rspError},
          32'h38);
    rst_n = 1'b1;
    @(negedge clk);
    check(memCeN && memWeN && memReN && !memDataOe && !rspReady && !rspError, "R12",
          "outputs after reset", {26'd0, memCeN, memWeN, memReN, memDataOe, rspReady, rspError},
          32'h38);

    // phase lengths, single byte write to 8-bit memory
    access(1, 2'd0, 32'h0000_005C, 0, 0, 1, 2, 1, 0, 0, "R1 R2 R3");
    // halfword write split in two, high-Z lead
    access(1, 2'd1, 32'h0000_B7E4, 0, 0, 3, 1, 2, 2, 0, "R6 R4");
    // word read on 8-bit memory, zero hold
    access(0, 2'd2, 0, 32'h8D3A_61F2, 0, 0, 0, 0, 0, 0, "R6 R5 R3");
    // word write on 8-bit memory
    access(1, 2'd2, 32'h1357_9BDF, 0, 0, 2, 3, 1, 1, 0, "R6 R4");
    // 16-bit memory word read
    access(0, 2'd2, 0, 32'hC0DE_4A71, 1, 1, 1, 1, 0, 0, "R7 R5");
    // 16-bit memory byte read, upper bits zero
    access(0, 2'd0, 0, 32'hFFFF_E39B, 1, 2, 0, 1, 0, 0, "R7");
    // 16-bit memory halfword write
    access(1, 2'd1, 32'h0000_6C2D, 0, 1, 0, 2, 0, 2, 0, "R7 R4");
    // rejected requests
    access(1, 2'd0, 32'h0000_0011, 0, 1, 1, 1, 1, 0, 0, "R8");
    access(0, 2'd3, 0, 32'h1234_5678, 0, 1, 1, 1, 0, 0, "R8");

    // busy held low but monitoring disabled
    memWaitN = 1'b0;
    repeat (4) @(negedge clk);
    access(0, 2'd1, 0, 32'h0000_2FA8, 0, 1, 1, 2, 0, 0, "R10");
    memWaitN = 1'b1;
    repeat (4) @(negedge clk);
    // monitoring on, device ready
    access(0, 2'd0, 0, 32'h0000_0076, 0, 1, 1, 1, 0, 1, "R9");

    // monitoring on, device busy
    memWaitN = 1'b0;
    repeat (4) @(negedge clk);
    startAccess(0, 2'd0, 0, 32'h0000_00C9, 0, 1, 1, 1, 0, 1, 1'b1, "R9");
    repeat (12) @(negedge clk);
    check(!memCeN && memReN && memWeN && sbQ.size() == 1, "R9", "stalled with chip enable low",
          {29'd0, memCeN, memReN, memWeN}, 32'd3);
    memWaitN = 1'b1;
    begin
      int relCycle;
      relCycle = cycleCnt;
      waitDone();
      check(doneCycle - relCycle == 3, "R9", "ready after release",
            32'(doneCycle - relCycle), 32'd3);
    end

    // timing values changed mid-access must not matter
    startAccess(1, 2'd0, 32'h0000_00A6, 0, 0, 4, 2, 2, 1, 0, 1'b0, "R11");
    cfgSetup = 8'd0; cfgWait = 8'd0; cfgHold = 8'd0; cfgHiz = 8'd0; cfgMemWide = 1'b1;
    waitDone();

    repeat (2) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule